// File: doc/BRIEF.md
# Multi-Tap Circular Buffer Delay Line

This block turns one incoming sample stream into several copies, each delayed by a fixed number of valid samples. A valid sample is one presented on a clock edge while the clock enable is high. Cycles with the enable low are gaps in the stream. They neither store a sample nor count toward any delay. The sample width defaults to one bit and is set by a parameter.

All history lives in one circular storage array with a power-of-two depth. A single write pointer stores each new sample. Each tap has its own read pointer, kept a fixed distance behind the write pointer. On every enabled edge, the write pointer and all read pointers step forward together. At the same edge, each tap register captures the word its read pointer addresses. Tap count and tap delays are compile-time parameters. Each delay lies between 1 and the depth minus 1.

Top module: `multi_tap_delay`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, every tap output is zero after that edge. Reset also restarts the sample count, so the stored history is treated as empty.
- R2: Count enabled edges from 0 after reset. After enabled edge m, tap k (bits k*WIDTH upward in `tap_q`) shows the sample taken at enabled edge m - TAP_DLY[k], provided m >= TAP_DLY[k].
- R3: At an edge where `ce` is low, every tap output keeps its value. No sample is stored.
- R4: Delays count enabled edges only. Any number of idle cycles between samples leaves the tap alignment of R2 unchanged.
- R5: The storage wraps from its last location to location zero. A tap with delay DEPTH-1 stays correct across any number of wraps. When a read addresses the location being written at the same edge, it returns the old contents.
- R6: Every tap carries the full WIDTH-bit word. Each bit position follows the R2 relation independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable: high marks a valid input sample |
| din | input | WIDTH | Input sample |
| tap_q | output | NTAPS*WIDTH | Registered tap outputs, tap k in bits [k*WIDTH +: WIDTH] |

## Verification
Every tap result is due at the first clock edge at which `ce` is sampled high. Only the tap register lies between the storage read and the port. The bench drives inputs on the falling edge. It reads `tap_q` 1 ns after the next rising edge. There it compares the taps against a sample history that advances only on enabled edges. It checks a tap only once at least its delay's worth of samples has been stored since reset. On disabled edges it compares each tap with the value read just before that edge. Random enable patterns, a long unbroken enabled run past several wraps, alternating full-width words and a reset in mid-stream cover the delay, hold and wrap cases.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

    // Reset position of a read pointer: zero minus the delay, modulo depth.
    function automatic int unsigned rd_start(int unsigned depth, int unsigned dly);
        return (depth - (dly % depth)) % depth;
    endfunction

endpackage

// File: rtl/mtd_ptr.sv
module mtd_ptr #(
    parameter int unsigned AW   = 4,
    parameter int unsigned INIT = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] START = AW'(INIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= START;
        end else if (ce) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/mtd_store.sv
module mtd_store #(
    parameter int unsigned WIDTH = 1,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned NRD   = 4,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [WIDTH-1:0]     wdata,
    input  logic [NRD*AW-1:0]    raddr,
    output logic [NRD*WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rdata[k*WIDTH +: WIDTH] = mem[raddr[k*AW +: AW]];
    end

endmodule

// File: rtl/multi_tap_delay.sv
module multi_tap_delay #(
    parameter int unsigned WIDTH          = 1,
    parameter int unsigned DEPTH          = 16,
    parameter int unsigned NTAPS          = 4,
    parameter int unsigned TAP_DLY [NTAPS] = '{1, 3, 7, 15}
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce,
    input  logic [WIDTH-1:0]       din,
    output logic [NTAPS*WIDTH-1:0] tap_q
);

    localparam int unsigned AW = $clog2(DEPTH);

    logic [AW-1:0]          wr_ptr;
    logic [NTAPS*AW-1:0]    rd_ptr_flat;
    logic [NTAPS*WIDTH-1:0] rd_word;

    mtd_ptr #(.AW(AW), .INIT(0)) u_wr_ptr (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .ptr (wr_ptr)
    );

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        mtd_ptr #(
            .AW   (AW),
            .INIT (mtd_pkg::rd_start(DEPTH, TAP_DLY[k]))
        ) u_rd_ptr (
            .clk (clk),
            .rst (rst),
            .ce  (ce),
            .ptr (rd_ptr_flat[k*AW +: AW])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                tap_q[k*WIDTH +: WIDTH] <= '0;
            end else if (ce) begin
                tap_q[k*WIDTH +: WIDTH] <= rd_word[k*WIDTH +: WIDTH];
            end
        end
    end

    mtd_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NRD(NTAPS)) u_store (
        .clk   (clk),
        .we    (ce),
        .waddr (wr_ptr),
        .wdata (din),
        .raddr (rd_ptr_flat),
        .rdata (rd_word)
    );

endmodule

// File: rtl/mtd_checker.sv
module mtd_checker #(
    parameter int unsigned WIDTH          = 1,
    parameter int unsigned DEPTH          = 16,
    parameter int unsigned NTAPS          = 4,
    parameter int unsigned TAP_DLY [NTAPS] = '{1, 3, 7, 15},
    localparam int unsigned AW            = $clog2(DEPTH)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   ce,
    input logic [NTAPS*WIDTH-1:0] tap_q,
    input logic [AW-1:0]          wr_ptr,
    input logic [NTAPS*AW-1:0]    rd_ptr_flat
);

    // R1: a reset edge leaves every tap at zero
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> tap_q == '0);

    // R3: a disabled edge changes no tap and no write pointer
    p_hold_taps_r3: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(tap_q));
    p_hold_ptr_r3: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(wr_ptr));

    // R4: the write pointer steps once per enabled edge
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        ce |=> wr_ptr == AW'($past(wr_ptr) + 1'b1));

    // R5: wrap from the last location to zero
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (ce && wr_ptr == AW'(DEPTH - 1)) |=> wr_ptr == '0);

    // R2: each read pointer trails the write pointer by its delay
    for (genvar k = 0; k < NTAPS; k++) begin : g_chk
        p_spacing_r2: assert property (@(posedge clk) disable iff (rst)
            AW'(wr_ptr - rd_ptr_flat[k*AW +: AW]) == AW'(TAP_DLY[k]));
    end

endmodule

bind multi_tap_delay mtd_checker #(
    .WIDTH   (WIDTH),
    .DEPTH   (DEPTH),
    .NTAPS   (NTAPS),
    .TAP_DLY (TAP_DLY)
) u_mtd_checker (
    .clk         (clk),
    .rst         (rst),
    .ce          (ce),
    .tap_q       (tap_q),
    .wr_ptr      (wr_ptr),
    .rd_ptr_flat (rd_ptr_flat)
);

// File: tb/multi_tap_delay_bench.sv
`timescale 1ns/1ps
module multi_tap_delay_bench;

    localparam int unsigned W  = 4;
    localparam int unsigned DP = 16;
    localparam int unsigned NT = 4;
    localparam int unsigned DL [NT] = '{1, 2, 9, 15};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce  = 1'b0;
    logic [W-1:0]    din = '0;
    logic [NT*W-1:0] tap_q;

    int nvec = 0;
    int nbad = 0;
    int cnt  = 0;
    logic [W-1:0] hist [256];
    bit done = 1'b0;

    always #5 clk = ~clk;

    multi_tap_delay #(.WIDTH(W), .DEPTH(DP), .NTAPS(NT), .TAP_DLY(DL)) u_multi_tap_delay (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .din   (din),
        .tap_q (tap_q)
    );

    function automatic logic [W-1:0] expect_tap(int m, int k);
        return hist[(m - int'(DL[k])) & 255];
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp, int k);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s tap %0d: actual %h expected %h at %0t", req, k, act, exp, $time);
        end
    endtask

    task automatic step(bit r, bit e, logic [W-1:0] d, string req);
        logic [NT*W-1:0] prev;
        @(negedge clk);
        prev = tap_q;
        rst = r;
        ce  = e;
        din = d;
        @(posedge clk);
        #1;
        if (r) begin
            cnt = 0;
            for (int k = 0; k < NT; k++) check("R1", tap_q[k*W +: W], '0, k);
        end else if (e) begin
            hist[cnt & 255] = d;
            for (int k = 0; k < NT; k++) begin
                if (cnt >= int'(DL[k])) check(req, tap_q[k*W +: W], expect_tap(cnt, k), k);
            end
            cnt++;
        end else begin
            for (int k = 0; k < NT; k++) check("R3", tap_q[k*W +: W], prev[k*W +: W], k);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        step(1'b1, 1'b0, '0, "R1");
        step(1'b1, 1'b1, 4'hF, "R1");
        // R2/R5: unbroken enabled run across several wraps
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1, W'($urandom), "R5");
        // R4/R3: random enable with random idle gaps
        for (int i = 0; i < 1500; i++)
            step(1'b0, ($urandom % 3) != 0, W'($urandom), "R4");
        // R6: alternating full-width words
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, (i % 2) ? 4'hA : 4'h5, "R6");
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, (i % 2) ? 4'hF : 4'h0, "R6");
        // R1: reset in mid-stream, then resume
        step(1'b1, 1'b1, 4'h7, "R1");
        for (int i = 0; i < 200; i++)
            step(1'b0, ($urandom % 4) != 0, W'($urandom), "R2");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule